// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end and embedded-operation controller of a byte-wide parallel NOR flash model. It watches chip-enable, output-enable and write-enable bus cycles sampled on the system clock, and decodes unlock and command sequences. When a sequence completes it launches a byte program, a sector erase or a chip erase. Each operation is internally timed and acts on a memory array held in registers. The array size and the three operation lengths are parameters. The defaults are small enough for fast simulation: 1024 bytes, and timers of tens of cycles.

A write cycle is a low pulse on write-enable while chip-enable is low and output-enable is high. The address is captured when write-enable falls. The data is captured when it rises, and the decoder acts on the cycle at that rising edge. While an operation runs, `busy` is high and every bus write is discarded. When the timer expires the array is updated, `busy` drops and the block is back in read mode. A static `boot_lock` level protects the boot region from chip erase.

Top module: `pflash_cmd_seq`

## Requirements
- R1: After reset `busy` is 0 and every array byte reads 0xFF.
- R2: A write cycle counts only when `ce_n`=0 and `oe_n`=1 on both the falling and the rising edge of `we_n`. The address is the value present when `we_n` falls, and the data is the value present when it rises. A pulse with `oe_n`=0 or `ce_n`=1 is discarded and leaves the decoder where it was.
- R3: Byte program takes four cycles: 0xAA at unlock address A, then 0x55 at unlock address B, then 0xA0 at A, then the data byte at the target address. Unlock address A is the low ADDR_W bits of 0x5555 and B is the low ADDR_W bits of 0x2AAA. The stored byte becomes the old byte ANDed with the new one.
- R4: `busy` rises in the cycle after the clock edge that takes the last command cycle. It stays high for exactly PROG_CYCLES, SERASE_CYCLES or CERASE_CYCLES cycles, depending on the operation. The array change is visible once `busy` is low.
- R5: Sector erase takes six cycles: 0xAA@A, 0x55@B, 0x80@A, 0xAA@A, 0x55@B, then 0x30 at any address. The sector holding that last address is set to 0xFF, and all other bytes are kept.
- R6: Sectors are chosen by the top four address bits. Values 0 to 7 are main sector A, 8 to 11 are main sector B, 12 is parameter sector A, 13 is parameter sector B, and 14 to 15 are the boot region.
- R7: A sector-erase sequence whose last address lies in the boot region has no effect and does not raise `busy`.
- R8: Chip erase is the sector-erase sequence with 0x10 at A as the sixth cycle. With `boot_lock`=0 it sets the whole array to 0xFF.
- R9: With `boot_lock`=1 when the sixth cycle is taken, chip erase sets every byte outside the boot region to 0xFF and leaves the boot bytes unchanged.
- R10: A cycle whose address or data does not fit the sequence so far is consumed and returns the decoder to its start state, with no change to the array.
- R11: Write cycles taken while `busy` is high are discarded. They neither extend nor start an operation.
- R12: `rdata` shows the array byte at `addr` when `ce_n`=0 and `oe_n`=0, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| boot_lock | input | 1 | Protects the boot region from chip erase when high |
| rdata | output | 8 | Read data |
| busy | output | 1 | High while an embedded operation runs |

## Verification
The hardest situation to reach from the ports is a complete, well-formed command sequence that arrives while an operation is still running. It must be discarded without shortening or extending the timer. The bench starts a program, then feeds a second full program sequence inside the busy window. It counts the remaining busy cycles and scans the whole array afterwards. The address and data capture on opposite edges is exercised in every cycle: the bench moves the address to its complement before `we_n` rises. Seeded random programs, erases, aborted sequences and bad command codes are run between full-array comparisons against a bench model.

// File: rtl/pfcs_pkg.sv
package pfcs_pkg;

   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_SERASE = 2'd1,
      OP_CERASE = 2'd2
   } op_e;

   typedef enum logic [2:0] {
      SEC_MAIN_A = 3'd0,
      SEC_MAIN_B = 3'd1,
      SEC_PARM_A = 3'd2,
      SEC_PARM_B = 3'd3,
      SEC_BOOT   = 3'd4
   } sec_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_UNL1  = 3'd1,
      ST_CMD   = 3'd2,
      ST_PDATA = 3'd3,
      ST_ERA1  = 3'd4,
      ST_ERA2  = 3'd5,
      ST_ERA3  = 3'd6
   } dstate_e;

   localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
   localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;

   localparam logic [7:0] CODE_UNLK_A = 8'hAA;
   localparam logic [7:0] CODE_UNLK_B = 8'h55;
   localparam logic [7:0] CODE_PROG   = 8'hA0;
   localparam logic [7:0] CODE_ESETUP = 8'h80;
   localparam logic [7:0] CODE_CHIP   = 8'h10;
   localparam logic [7:0] CODE_SECTOR = 8'h30;

   // the upper four address bits pick the sector
   function automatic sec_e sec_of_unit(input logic [3:0] unit);
      sec_e s;
      if (unit < 4'd8)        s = SEC_MAIN_A;
      else if (unit < 4'd12)  s = SEC_MAIN_B;
      else if (unit == 4'd12) s = SEC_PARM_A;
      else if (unit == 4'd13) s = SEC_PARM_B;
      else                    s = SEC_BOOT;
      return s;
   endfunction

endpackage

// File: rtl/pfcs_buscyc.sv
module pfcs_buscyc #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              cyc_stb,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [7:0]        cyc_data
);

   logic              we_q;
   logic              armed;
   logic [ADDR_W-1:0] addr_lat;
   logic              wr_sel;
   logic              we_fall;
   logic              we_rise;

   assign wr_sel  = !ce_n && oe_n;
   assign we_fall = we_q && !we_n;
   assign we_rise = !we_q && we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q     <= 1'b1;
         armed    <= 1'b0;
         addr_lat <= '0;
      end else begin
         we_q <= we_n;
         if (we_fall) begin
            armed <= wr_sel;
            if (wr_sel) addr_lat <= addr;
         end else if (we_rise) begin
            armed <= 1'b0;
         end
      end
   end

   assign cyc_stb  = we_rise && wr_sel && armed;
   assign cyc_addr = addr_lat;
   assign cyc_data = wdata;

   // R2: a taken cycle always follows a low write-enable sample
   assert_stb_after_low_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_stb |-> $past(!we_n));

endmodule

// File: rtl/pfcs_decode.sv
module pfcs_decode
   import pfcs_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_stb,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [7:0]        cyc_data,
   input  logic              busy,
   output logic              start,
   output op_e               start_op
);

   localparam int CMP_W = (ADDR_W < 15) ? ADDR_W : 15;

   dstate_e state;
   dstate_e state_nxt;
   logic    at_a;
   logic    at_b;
   logic    boot_hit;

   assign at_a     = cyc_addr[CMP_W-1:0] == UNLOCK_ADDR_A[CMP_W-1:0];
   assign at_b     = cyc_addr[CMP_W-1:0] == UNLOCK_ADDR_B[CMP_W-1:0];
   assign boot_hit = sec_of_unit(cyc_addr[ADDR_W-1 -: 4]) == SEC_BOOT;

   always_comb begin
      state_nxt = state;
      start     = 1'b0;
      start_op  = OP_PROG;
      if (cyc_stb) begin
         case (state)
            ST_IDLE:
               state_nxt = (at_a && cyc_data == CODE_UNLK_A) ? ST_UNL1 : ST_IDLE;
            ST_UNL1:
               state_nxt = (at_b && cyc_data == CODE_UNLK_B) ? ST_CMD : ST_IDLE;
            ST_CMD: begin
               if (at_a && cyc_data == CODE_PROG)        state_nxt = ST_PDATA;
               else if (at_a && cyc_data == CODE_ESETUP) state_nxt = ST_ERA1;
               else                                      state_nxt = ST_IDLE;
            end
            ST_PDATA: begin
               start     = 1'b1;
               start_op  = OP_PROG;
               state_nxt = ST_IDLE;
            end
            ST_ERA1:
               state_nxt = (at_a && cyc_data == CODE_UNLK_A) ? ST_ERA2 : ST_IDLE;
            ST_ERA2:
               state_nxt = (at_b && cyc_data == CODE_UNLK_B) ? ST_ERA3 : ST_IDLE;
            ST_ERA3: begin
               state_nxt = ST_IDLE;
               if (at_a && cyc_data == CODE_CHIP) begin
                  start    = 1'b1;
                  start_op = OP_CERASE;
               end else if (cyc_data == CODE_SECTOR && !boot_hit) begin
                  start    = 1'b1;
                  start_op = OP_SERASE;
               end
            end
            default: state_nxt = ST_IDLE;
         endcase
      end
      if (busy) begin
         state_nxt = ST_IDLE;
         start     = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nxt;
   end

   // R11: a running operation holds the decoder in its start state
   assert_idle_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> state == ST_IDLE);

   // R10: leaving the start state needs the first unlock cycle
   assert_enter_needs_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_IDLE && state != ST_IDLE) |-> $past(cyc_stb && cyc_data == CODE_UNLK_A));

endmodule

// File: rtl/pfcs_engine.sv
module pfcs_engine
   import pfcs_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int PROG_CYCLES   = 20,
   parameter int SERASE_CYCLES = 60,
   parameter int CERASE_CYCLES = 90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_e               start_op,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [7:0]        start_data,
   input  logic              boot_lock,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic [7:0]        rd_data
);

   localparam int DEPTH    = 1 << ADDR_W;
   localparam int MAX_A    = (PROG_CYCLES > SERASE_CYCLES) ? PROG_CYCLES : SERASE_CYCLES;
   localparam int MAX_CYC  = (MAX_A > CERASE_CYCLES) ? MAX_A : CERASE_CYCLES;
   localparam int CNT_W    = $clog2(MAX_CYC + 1);
   localparam int BOOT_IDX = (DEPTH / 16) * 14;

   logic [7:0]        mem [DEPTH];
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  load_val;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic              lock_q;
   sec_e              tgt_sec;
   logic              fin;

   always_comb begin
      case (start_op)
         OP_SERASE: load_val = CNT_W'(SERASE_CYCLES - 1);
         OP_CERASE: load_val = CNT_W'(CERASE_CYCLES - 1);
         default:   load_val = CNT_W'(PROG_CYCLES - 1);
      endcase
   end

   assign fin     = busy && (cnt == '0);
   assign tgt_sec = sec_of_unit(addr_q[ADDR_W-1 -: 4]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         lock_q <= 1'b0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         cnt    <= load_val;
         op_q   <= start_op;
         addr_q <= start_addr;
         data_q <= start_data;
         lock_q <= boot_lock;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (fin) begin
         for (int i = 0; i < DEPTH; i++) begin
            case (op_q)
               OP_PROG:
                  if (addr_q == ADDR_W'(i)) mem[i] <= mem[i] & data_q;
               OP_SERASE:
                  if (sec_of_unit(4'(i >> (ADDR_W - 4))) == tgt_sec) mem[i] <= 8'hFF;
               OP_CERASE:
                  if (!(lock_q && sec_of_unit(4'(i >> (ADDR_W - 4))) == SEC_BOOT))
                     mem[i] <= 8'hFF;
               default: ;
            endcase
         end
      end
   end

   assign rd_data = mem[rd_addr];

   // R11: the decoder never launches into a running operation
   assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && busy));

   // R4: busy only rises on a launch from the decoder
   assert_busy_rise_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R3: programming only clears bits
   assert_prog_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && op_q == OP_PROG) |=> mem[addr_q] == ($past(mem[addr_q]) & data_q));

   // R5: the addressed byte of an erased sector reads erased
   assert_erase_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && op_q == OP_SERASE) |=> mem[addr_q] == 8'hFF);

   // R9: a locked chip erase keeps the boot region
   assert_boot_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && op_q == OP_CERASE && lock_q) |=> $stable(mem[BOOT_IDX]));

endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
   import pfcs_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int PROG_CYCLES   = 20,
   parameter int SERASE_CYCLES = 60,
   parameter int CERASE_CYCLES = 90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              boot_lock,
   output logic [7:0]        rdata,
   output logic              busy
);

   generate
      if (ADDR_W < 8 || ADDR_W > 20) begin : g_bad_addr_w
         $error("pflash_cmd_seq: ADDR_W must lie in 8..20");
      end
      if (PROG_CYCLES < 1 || SERASE_CYCLES < 1 || CERASE_CYCLES < 1) begin : g_bad_cycles
         $error("pflash_cmd_seq: operation lengths must be at least one cycle");
      end
   endgenerate

   logic              cyc_stb;
   logic [ADDR_W-1:0] cyc_addr;
   logic [7:0]        cyc_data;
   logic              start;
   op_e               start_op;
   logic [7:0]        rd_data;

   pfcs_buscyc #(.ADDR_W(ADDR_W)) u_buscyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .addr     (addr),
      .wdata    (wdata),
      .cyc_stb  (cyc_stb),
      .cyc_addr (cyc_addr),
      .cyc_data (cyc_data)
   );

   pfcs_decode #(.ADDR_W(ADDR_W)) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_stb  (cyc_stb),
      .cyc_addr (cyc_addr),
      .cyc_data (cyc_data),
      .busy     (busy),
      .start    (start),
      .start_op (start_op)
   );

   pfcs_engine #(
      .ADDR_W        (ADDR_W),
      .PROG_CYCLES   (PROG_CYCLES),
      .SERASE_CYCLES (SERASE_CYCLES),
      .CERASE_CYCLES (CERASE_CYCLES)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_op   (start_op),
      .start_addr (cyc_addr),
      .start_data (cyc_data),
      .boot_lock  (boot_lock),
      .rd_addr    (addr),
      .busy       (busy),
      .rd_data    (rd_data)
   );

   assign rdata = (!ce_n && !oe_n) ? rd_data : 8'h00;

endmodule

// File: tb/tb_pflash_cmd_seq.sv
module tb_pflash_cmd_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 10;
   localparam int DEPTH      = 1 << AW;
   localparam int PROG_CYC   = 20;
   localparam int SE_CYC     = 60;
   localparam int CE_CYC     = 90;
   localparam logic [AW-1:0] UA = 10'h155;
   localparam logic [AW-1:0] UB = 10'h2AA;

   logic          clk;
   logic          rst_n;
   logic          ce_n;
   logic          oe_n;
   logic          we_n;
   logic [AW-1:0] addr;
   logic [7:0]    wdata;
   logic          boot_lock;
   logic [7:0]    rdata;
   logic          busy;

   int         n_chk;
   int         n_fail;
   logic [7:0] model [DEPTH];

   pflash_cmd_seq #(
      .ADDR_W(AW), .PROG_CYCLES(PROG_CYC), .SERASE_CYCLES(SE_CYC), .CERASE_CYCLES(CE_CYC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .boot_lock(boot_lock), .rdata(rdata), .busy(busy)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int sec_of(input int a);
      int u;
      u = a >> (AW - 4);
      if (u < 8)       return 0;
      else if (u < 12) return 1;
      else if (u == 12) return 2;
      else if (u == 13) return 3;
      return 4;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wcyc(input logic [AW-1:0] a, input logic [7:0] d,
                       input logic ce_v, input logic oe_v);
      @(negedge clk);
      ce_n = ce_v; oe_n = oe_v; addr = a; wdata = ~d; we_n = 1'b0;
      @(negedge clk);
      addr = ~a; wdata = d; we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wgood(input logic [AW-1:0] a, input logic [7:0] d);
      wcyc(a, d, 1'b0, 1'b1);
   endtask

   task automatic wait_busy(input int expc, input string req);
      int n = 0;
      while (busy && n < expc + 10) begin
         n++;
         @(negedge clk);
      end
      check(n == expc, req, n, expc);
   endtask

   task automatic scan(input string req);
      int bad = 0;
      int fa = 0;
      int fe = 0;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         ce_n = 1'b0; oe_n = 1'b0; addr = AW'(i);
         #1;
         if (rdata !== model[i]) begin
            if (bad == 0) begin fa = int'(rdata); fe = int'(model[i]); end
            bad++;
         end
      end
      ce_n = 1'b1; oe_n = 1'b1;
      check(bad == 0, req, fa, fe);
   endtask

   task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
      wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(UA, 8'hA0); wgood(a, d);
      model[a] = model[a] & d;
      wait_busy(PROG_CYC, "R4 program busy length");
   endtask

   task automatic erase_head();
      wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(UA, 8'h80);
      wgood(UA, 8'hAA); wgood(UB, 8'h55);
   endtask

   task automatic do_serase(input logic [AW-1:0] a);
      erase_head();
      wgood(a, 8'h30);
      if (sec_of(int'(a)) == 4) begin
         check(busy == 1'b0, "R7 boot sector erase raises busy", int'(busy), 0);
      end else begin
         for (int i = 0; i < DEPTH; i++)
            if (sec_of(i) == sec_of(int'(a))) model[i] = 8'hFF;
         wait_busy(SE_CYC, "R5 sector erase busy length");
      end
   endtask

   task automatic do_cerase(input logic lock);
      boot_lock = lock;
      erase_head();
      wgood(UA, 8'h10);
      for (int i = 0; i < DEPTH; i++)
         if (!(lock && sec_of(i) == 4)) model[i] = 8'hFF;
      wait_busy(CE_CYC, "R8 chip erase busy length");
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int seed;
      n_chk = 0; n_fail = 0;
      seed = int'($urandom(32'h5EED_0042));
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      addr = '0; wdata = '0; boot_lock = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R12: reset state and quiet read bus
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      addr = 10'h040; #1;
      check(rdata == 8'h00, "R12 rdata with oe_n high", int'(rdata), 0);
      scan("R1 array erased after reset");

      // R3: program then AND on a second program
      do_prog(10'h040, 8'h5A);
      do_prog(10'h040, 8'hF0);
      scan("R3 program result is AND");

      // R2: cycles with oe_n low or ce_n high are discarded
      wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(UA, 8'hA0);
      wcyc(10'h081, 8'h00, 1'b0, 1'b0);
      check(busy == 1'b0, "R2 oe_n low cycle taken", int'(busy), 0);
      wcyc(10'h081, 8'h00, 1'b1, 1'b1);
      check(busy == 1'b0, "R2 ce_n high cycle taken", int'(busy), 0);
      wgood(10'h081, 8'h0F);
      model[10'h081] = model[10'h081] & 8'h0F;
      wait_busy(PROG_CYC, "R2 program after discarded cycles");
      scan("R2 only the valid cycle programmed");

      // R10: bad data, then bad address, abort
      wgood(UA, 8'hAA); wgood(UB, 8'h77); wgood(10'h090, 8'h00);
      check(busy == 1'b0, "R10 bad data aborts", int'(busy), 0);
      wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(10'h001, 8'hA0); wgood(10'h091, 8'h00);
      check(busy == 1'b0, "R10 bad address aborts", int'(busy), 0);
      scan("R10 aborted sequences change nothing");
      do_prog(10'h092, 8'h33);
      scan("R10 decoder back in start state");

      // R6 / R5: seed every region, then erase each sector in turn
      do_prog(10'h010, 8'h01);
      do_prog(10'h210, 8'h02);
      do_prog(10'h305, 8'h03);
      do_prog(10'h345, 8'h04);
      do_prog(10'h3C1, 8'h05);
      do_serase(10'h300);
      scan("R6 parameter sector A bounds");
      do_serase(10'h37F);
      scan("R6 parameter sector B bounds");
      do_serase(10'h2FF);
      scan("R5 main sector B erase");
      do_serase(10'h000);
      scan("R5 main sector A erase");

      // R7: boot address in sector erase does nothing
      do_serase(10'h3C1);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R7 boot erase stays idle", int'(busy), 0);
      scan("R7 boot byte kept");

      // R11: full sequence during busy is discarded
      wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(UA, 8'hA0); wgood(10'h120, 8'h81);
      model[10'h120] = model[10'h120] & 8'h81;
      wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(UA, 8'hA0); wgood(10'h121, 8'h00);
      wait_busy(PROG_CYC - 12, "R11 busy length unchanged");
      repeat (4) @(negedge clk);
      check(busy == 1'b0, "R11 no second launch", int'(busy), 0);
      scan("R11 ignored program left no trace");

      // R9 then R8: chip erase with and without lock
      do_prog(10'h3FE, 8'h11);
      do_prog(10'h200, 8'h22);
      do_cerase(1'b1);
      scan("R9 locked chip erase keeps boot");
      do_cerase(1'b0);
      scan("R8 unlocked chip erase clears all");

      // seeded random mix
      for (int it = 0; it < 40; it++) begin
         int kind;
         logic [AW-1:0] ra;
         logic [7:0]    rd;
         kind = int'($urandom % 10);
         ra   = AW'($urandom);
         rd   = 8'($urandom);
         if (kind <= 5) begin
            do_prog(ra, rd);
            scan("R3 random program");
         end else if (kind == 6) begin
            do_serase(ra);
            scan("R5 random sector erase");
         end else if (kind == 7) begin
            wgood(UA, 8'hAA); wgood(ra, 8'h55);
            if (ra == UB) begin
               wgood(UA, 8'h00);
            end
            check(busy == 1'b0, "R10 random abort", int'(busy), 0);
            do_prog(ra, rd);
            scan("R10 program after random abort");
         end else if (kind == 8) begin
            do_cerase(rd[0]);
            scan("R9 random chip erase");
         end else begin
            wgood(UA, 8'hAA); wgood(UB, 8'h55); wgood(UA, 8'h90); wgood(ra, rd);
            check(busy == 1'b0, "R10 unknown command code", int'(busy), 0);
            scan("R10 unknown command leaves array");
         end
      end

      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b0; addr = 10'h040; #1;
      check(rdata == 8'h00, "R12 rdata with ce_n high", int'(rdata), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule